// File: doc/BRIEF.md
# Shared-Source Stochastic Bitstream Generator

This block turns a group of unsigned 8-bit operands into parallel unipolar stochastic bitstreams. A single maximal-length 8-bit LFSR supplies the random words for every lane. Each lane compares its operand against a copy of the LFSR word whose bit positions have been reordered. The reordering is pure wiring. Lane `k` builds the bit at position `p` of its compare word from LFSR bit `p XOR k`, with `p` and `k` taken as 3-bit indices. Lane 0 therefore sees the LFSR word unchanged. Giving each lane a different reordering weakens the correlation between the streams, so a downstream AND gate (multiply) or multiplexer (scaled add) produces a usable result without one random source per operand.

A one-cycle start strobe does three things: it captures the operands, it loads the LFSR from a seed, and it begins a conversion of exactly 256 cycles. The LFSR visits each of its 255 nonzero states once. In the final cycle the compare word is forced to zero. Because of this, the number of ones in each stream equals the operand value exactly. The done flag marks the last bit.

Top module: `shared_lfsr_sng`

## Requirements
- R1: During a conversion, the output bit of each lane is 1 exactly when that lane's compare word is less than its captured operand, with both treated as unsigned. Otherwise the bit is 0.
- R2: The LFSR shifts left by one place each cycle. The new bit 0 is the XOR of old bits 7, 5, 4 and 3. The first compare word of a conversion is the seed. A seed of zero is replaced by 8'h01, and the LFSR state is never zero.
- R3: The compare word of lane k takes the bit at position p from LFSR bit (p XOR k). Lane 0 uses the LFSR word without change.
- R4: A conversion lasts exactly 256 cycles with `valid_o` high. In the 256th cycle the compare word of every lane is zero. Each lane therefore emits exactly as many ones as its operand value.
- R5: `done_o` is high in the 256th cycle of a conversion and in no other cycle. In the cycle after it, `valid_o` is low.
- R6: Operands are captured on the accepted start. Changes on `operand_i` during a conversion have no effect on the streams.
- R7: A start strobe that arrives while a conversion is running is ignored. The running conversion continues unchanged, and its seed is not reloaded.
- R8: After reset and whenever no conversion is running, `valid_o`, `done_o` and every bit of `bits_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe, accepted only while idle |
| seed_i | input | 8 | LFSR seed for the next conversion (zero is replaced by 8'h01) |
| operand_i | input | LANES*8 | Operands; lane k uses bits [8k+7:8k] |
| bits_o | output | LANES | One stream bit per lane per cycle |
| valid_o | output | 1 | High during the 256 cycles of a conversion |
| done_o | output | 1 | High in the last cycle of a conversion |

## Verification
The hardest case to reach from the ports is a start strobe combined with new operand values in the middle of a running conversion. Only that case shows whether the LFSR reload and the operand capture are properly gated by the busy state. Some conversions in the stimulus therefore raise `start_i` with a fresh seed and new random operands partway through. Every remaining stream bit is then compared against the model built from the original seed and the original operands. Directed runs add a zero seed, operands of 0, 1 and 255, and a seed of 8'hFF, which cover the lock-up substitution and the exact ones count at both ends of the range.

// File: rtl/sng_pkg.sv
package sng_pkg;
  localparam int WORD_W = 8;
  // Feedback mask: bits 7,5,4,3 of the state (x^8+x^6+x^5+x^4+1)
  localparam logic [WORD_W-1:0] FB_MASK = 8'hB8;
  localparam logic [WORD_W-1:0] SAFE_SEED = 8'h01;
  localparam int CONV_LEN = 1 << WORD_W;
endpackage

// File: rtl/sng_lfsr.sv
module sng_lfsr
  import sng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] seed_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] state_o
);
  logic [WORD_W-1:0] state_q, state_d;
  logic              fb;

  always_comb begin
    fb      = ^(state_q & FB_MASK);
    state_d = state_q;
    if (load_i)      state_d = (seed_i == '0) ? SAFE_SEED : seed_i;
    else if (step_i) state_d = {state_q[WORD_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 state_q <= SAFE_SEED;
    else if (load_i || step_i)  state_q <= state_d;
  end

  assign state_o = state_q;

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R2
  AST_SHIFT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> state_q[WORD_W-1:1] == $past(state_q[WORD_W-2:0])); // R2
endmodule

// File: rtl/sng_ctrl.sv
module sng_ctrl
  import sng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic last_o
);
  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(CONV_LEN - 1);

  logic              busy_q, busy_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    accept_o = start_i && !busy_q;
    last_o   = busy_q && (cnt_q == LAST_IDX);
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    cnt_en   = accept_o || busy_q;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_o); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && cnt_q == WORD_W'($past(cnt_q) + 1'b1))); // R7
  AST_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> cnt_q == '0); // R4
endmodule

// File: rtl/sng_lane.sv
module sng_lane
  import sng_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              zero_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] operand_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] perm;
  logic [WORD_W-1:0] cmp_word;

  for (genvar p = 0; p < WORD_W; p++) begin : g_wire
    localparam int SRC = p ^ LANE;
    assign perm[p] = word_i[SRC];
  end

  always_comb begin
    cmp_word = zero_i ? '0 : perm;
    bit_o    = en_i && (cmp_word < operand_i);
  end

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (operand_i == '0) |-> !bit_o); // R1
  AST_PAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && zero_i && operand_i != '0) |-> bit_o); // R4
endmodule

// File: rtl/shared_lfsr_sng.sv
module shared_lfsr_sng
  import sng_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WORD_W-1:0]        seed_i,
  input  logic [LANES*WORD_W-1:0]  operand_i,
  output logic [LANES-1:0]         bits_o,
  output logic                     valid_o,
  output logic                     done_o
);
  localparam int OPND_W = LANES * WORD_W;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              accept, busy, last;
  logic [WORD_W-1:0] lfsr_word;
  logic [OPND_W-1:0] opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  sng_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last)
  );

  sng_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_s),
    .load_i  (accept),
    .seed_i  (seed_i),
    .step_i  (busy),
    .state_o (lfsr_word)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      opnd_q <= '0;
    else if (accept) opnd_q <= operand_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sng_lane #(.LANE(k)) u_lane (
      .clk       (clk),
      .rst_n     (rst_s),
      .en_i      (busy),
      .zero_i    (last),
      .word_i    (lfsr_word),
      .operand_i (opnd_q[k*WORD_W +: WORD_W]),
      .bit_o     (bits_o[k])
    );
  end

  assign valid_o = busy;
  assign done_o  = last;

  AST_OPND_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> $stable(opnd_q)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !valid_o |-> (bits_o == '0 && !done_o)); // R8
  AST_DONE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |-> valid_o); // R5
endmodule

// File: tb/sim_shared_lfsr_sng.sv
`timescale 1ns/1ps
module sim_shared_lfsr_sng;
  localparam int LANES = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 start_i;
  logic [7:0]           seed_i;
  logic [LANES*8-1:0]   operand_i;
  logic [LANES-1:0]     bits_o;
  logic                 valid_o;
  logic                 done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shared_lfsr_sng #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
    .operand_i(operand_i), .bits_o(bits_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [7:0] step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] remap(input logic [7:0] w, input int k);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) r[p] = w[p ^ k];
    return r;
  endfunction

  function automatic logic [LANES*8-1:0] rand_ops();
    logic [LANES*8-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [7:0] seed, input logic [LANES*8-1:0] ops,
                          input bit disturb);
    logic [7:0] m, w;
    int ones [LANES];
    int bad, bad_first, bad_valid, bad_done;
    bit e;
    bad = 0; bad_first = 0; bad_valid = 0; bad_done = 0;
    for (int k = 0; k < LANES; k++) ones[k] = 0;
    @(negedge clk);
    start_i = 1'b1; seed_i = seed; operand_i = ops;
    @(negedge clk);
    start_i = 1'b0;
    m = (seed == 8'h00) ? 8'h01 : seed;
    for (int i = 0; i < 256; i++) begin
      w = (i == 255) ? 8'h00 : m;
      for (int k = 0; k < LANES; k++) begin
        e = (remap(w, k) < ops[k*8 +: 8]);
        if (bits_o[k] !== e) begin
          bad++;
          if (i == 0) bad_first++;
        end
        if (bits_o[k] === 1'b1) ones[k]++;
      end
      if (valid_o !== 1'b1) bad_valid++;
      if (done_o !== (i == 255)) bad_done++;
      if (disturb && i == 90) begin
        start_i = 1'b1; seed_i = 8'($urandom); operand_i = rand_ops();
      end
      if (disturb && i == 91) start_i = 1'b0;
      m = step(m);
      @(negedge clk);
    end
    chk(bad_first == 0, "R2 first word from seed", bad_first, 0);
    chk(bad == 0, disturb ? "R1 R3 R6 R7 stream bits" : "R1 R3 stream bits", bad, 0);
    for (int k = 0; k < LANES; k++)
      chk(ones[k] == int'(ops[k*8 +: 8]), "R4 ones count", ones[k], int'(ops[k*8 +: 8]));
    chk(bad_valid == 0, "R4 valid length", bad_valid, 0);
    chk(bad_done == 0, "R5 done position", bad_done, 0);
    chk(valid_o === 1'b0 && done_o === 1'b0 && bits_o === '0,
        "R5 R8 idle after done", int'({valid_o, done_o}), 0);
  endtask

  initial begin
    #800_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LANES*8-1:0] ops;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; start_i = 1'b0; seed_i = '0; operand_i = '0;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && done_o === 1'b0 && bits_o === '0, "R8 reset state",
        int'(bits_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && bits_o === '0, "R8 idle before start", int'(bits_o), 0);

    ops = {8'd255, 8'd0, 8'd1, 8'd128, 8'd2, 8'd254, 8'd64, 8'd0};
    run_conv(8'h00, ops, 1'b0);
    run_conv(8'hFF, {LANES{8'd255}}, 1'b0);
    run_conv(8'h01, {LANES{8'd1}}, 1'b1);
    for (int n = 0; n < 8; n++)
      run_conv(8'($urandom), rand_ops(), n[0]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule